// File: doc/BRIEF.md
# Serial Command Slot Register Port

This block sits on the codec side of a five-wire audio link. It turns the controller's outbound serial frame into register traffic. A rising edge of the frame strobe marks the start of a frame. The frame is a 16-bit tag followed by twelve 20-bit slots, and every slot is sent most significant bit first. The block samples the data pin whenever the sample enable is high; the enable stands in for the falling edge of the bit clock. It splits each frame into slots and reads the command word from slot 1 and the data word from slot 2.

A write command updates one entry of a bank of 16-bit control registers, and the whole bank is exposed on a flat output bus. A read command captures the target index and the register value into a response holder. The outbound frame serializer collects that response over a valid/ready handshake and sends it in the next input frame. Back-pressure is limited because the serial stream cannot be stalled. The response stays valid, with stable contents, until ready is seen. A new read that arrives while a response is still pending replaces its contents, and valid stays high. When a new read and ready fall in the same cycle, the new read wins.

Two frame-level flags are also kept. The first reports a command word whose reserved bits are not zero. The second reports a frame in which the left and right PCM slots are both marked valid but carry different samples, which breaks the rule for mono streams.

Top module: `ac_cmd_port`

## Requirements
- R1: After reset, register index 00h reads the capability constant CAP_VALUE (default 16'h6A90) and every other register reads zero. rsp_valid, proto_err and mono_mismatch are all low.
- R2: Framing. With bit_en high, a sample where sync is 1 after a previous sample of 0 is the first tag bit. The tag takes 16 samples and each of the twelve slots takes 20, all MSB first. Tag bit 15 means the frame is valid, and tag bits 14, 13, 12 and 11 mark slots 1, 2, 3 and 4 as valid.
- R3: In slot 1, bit 19 gives the command type (1 = read, 0 = write) and bits 18:12 give the 7-bit register index. Register index n/2 lives at reg_q[(n/2)*16 +: 16].
- R4: A write executes only when the frame, slot 1 and slot 2 are all marked valid and the index is even. The register then takes slot 2 bits 19:4, and slot 2 bits 3:0 are ignored.
- R5: A write is ignored when the tag does not mark slot 2 valid or does not mark the frame valid.
- R6: A write to an odd index changes no register. A read of an odd index returns rsp_data 0000h.
- R7: A write to index 00h leaves it unchanged. A read of index 00h returns CAP_VALUE.
- R8: A valid read (frame and slot 1 valid, reserved bits zero) raises rsp_valid and presents the 7-bit index on rsp_index and the register value on rsp_data.
- R9: rsp_valid, rsp_index and rsp_data hold until rsp_ready is high in a cycle where rsp_valid is high, and the handshake then clears rsp_valid. A later read replaces a pending response.
- R10: At the end of a valid slot 1, proto_err is set to 1 if slot 1 bits 11:0 are nonzero and to 0 otherwise. A command with nonzero reserved bits is dropped: it neither writes nor answers.
- R11: At the end of slot 4, mono_mismatch is set to 1 only when the frame, slot 3 and slot 4 are all marked valid and the two 20-bit words differ. Otherwise it is set to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| bit_en | input | 1 | Sample enable, one per serial bit |
| sync | input | 1 | Frame strobe |
| sdata | input | 1 | Outbound serial data |
| rsp_valid | output | 1 | Read response available |
| rsp_ready | input | 1 | Response consumed by serializer |
| rsp_index | output | 7 | Index of the read register |
| rsp_data | output | 16 | Value of the read register |
| reg_q | output | NREG*16 | Flat contents of the register bank |
| proto_err | output | 1 | Reserved command bits were nonzero |
| mono_mismatch | output | 1 | Valid left and right PCM slots differ |

## Verification
Writes to the low, middle and top even indices use data that differs from what each register already holds, so a misrouted address or a shifted field shows up as a wrong value. Every slot 2 carries a nonzero low nibble, which exposes any leak of bits 3:0 into a register. Frames with slot 2 or the frame bit unmarked, writes to odd indices and writes to 00h separate execution from suppression. Reads of odd indices, of 00h and of a response left pending across a later frame separate the index path, the data path and the hold behaviour. Separate frames with equal PCM slots, unequal PCM slots and slot 4 unmarked separate the mismatch condition from plain word comparison, and a command with a reserved bit set, followed by a clean command, checks both setting and clearing of the error flag.

// File: rtl/ac_cmd_pkg.sv
package ac_cmd_pkg;
  localparam int TAG_BITS  = 16;
  localparam int SLOT_BITS = 20;
  localparam int NUM_SLOTS = 12;
  localparam int IDX_W     = 7;
  localparam int REG_W     = 16;
  localparam int RSVD_W    = SLOT_BITS - 1 - IDX_W;
  localparam int TAGV_W    = 5;   // frame, slot1..slot4 valid marks

  typedef struct packed {
    logic              rd;
    logic [IDX_W-1:0]  idx;
    logic [RSVD_W-1:0] rsvd;
  } cmd_t;

  typedef struct packed {
    logic frame;
    logic s1;
    logic s2;
    logic s3;
    logic s4;
  } tagv_t;
endpackage

// File: rtl/ac_frame_deser.sv
module ac_frame_deser
  import ac_cmd_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bit_en,
  input  logic                 sync,
  input  logic                 sdata,
  output logic                 slot_vld,
  output logic [3:0]           slot_num,
  output logic [SLOT_BITS-1:0] slot_word,
  output tagv_t                tagv
);
  logic                 sync_q;
  logic                 active;
  logic [4:0]           cnt;
  logic [3:0]           idx;
  logic [SLOT_BITS-1:0] sh;
  logic [SLOT_BITS-1:0] nxt;
  logic [4:0]           limit;

  assign nxt   = {sh[SLOT_BITS-2:0], sdata};
  assign limit = (idx == 4'd0) ? 5'(TAG_BITS - 1) : 5'(SLOT_BITS - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q    <= 1'b0;
      active    <= 1'b0;
      cnt       <= '0;
      idx       <= '0;
      sh        <= '0;
      slot_vld  <= 1'b0;
      slot_num  <= '0;
      slot_word <= '0;
      tagv      <= '0;
    end else begin
      slot_vld <= 1'b0;
      if (bit_en) begin
        sync_q <= sync;
        sh     <= nxt;
        if (sync && !sync_q) begin
          active <= 1'b1;
          idx    <= '0;
          cnt    <= 5'd1;
        end else if (active) begin
          if (cnt == limit) begin
            cnt <= '0;
            if (idx == 4'd0) begin
              tagv <= tagv_t'(nxt[TAG_BITS-1 -: TAGV_W]);
            end else begin
              slot_vld  <= 1'b1;
              slot_num  <= idx;
              slot_word <= nxt;
            end
            if (idx == 4'(NUM_SLOTS)) active <= 1'b0;
            else                      idx    <= idx + 4'd1;
          end else begin
            cnt <= cnt + 5'd1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/ac_reg_bank.sv
module ac_reg_bank
  import ac_cmd_pkg::*;
#(
  parameter int              NREG      = 64,
  parameter logic [REG_W-1:0] CAP_VALUE = 16'h6A90,
  localparam int             RA_W      = $clog2(NREG)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [RA_W-1:0]       wr_addr,
  input  logic [REG_W-1:0]      wr_data,
  input  logic [RA_W-1:0]       rd_addr,
  output logic [REG_W-1:0]      rd_data,
  output logic [NREG*REG_W-1:0] regs_flat
);
  logic [REG_W-1:0] regs [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (i == 0) begin : g_cap
      assign regs[i] = CAP_VALUE;
    end else begin : g_rw
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             regs[i] <= '0;
        else if (wr_en && wr_addr == RA_W'(i))  regs[i] <= wr_data;
      end
    end
    assign regs_flat[i*REG_W +: REG_W] = regs[i];
  end

  assign rd_data = regs[rd_addr];
endmodule

// File: rtl/ac_cmd_exec.sv
module ac_cmd_exec
  import ac_cmd_pkg::*;
#(
  parameter int  NREG = 64,
  localparam int RA_W = $clog2(NREG)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 slot_vld,
  input  logic [3:0]           slot_num,
  input  logic [SLOT_BITS-1:0] slot_word,
  input  tagv_t                tagv,
  input  logic [REG_W-1:0]     rd_data,
  output logic [RA_W-1:0]      rd_addr,
  output logic                 wr_en,
  output logic [RA_W-1:0]      wr_addr,
  output logic [REG_W-1:0]     wr_data,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic [IDX_W-1:0]     rsp_index,
  output logic [REG_W-1:0]     rsp_data,
  output logic                 proto_err,
  output logic                 mono_mismatch
);
  localparam logic [IDX_W-1:0] NREG_L = IDX_W'(NREG);

  cmd_t                 cur;
  logic [IDX_W-2:0]     idx_hi;
  logic                 in_range;
  logic                 cmd_ok;
  logic                 wr_pend;
  logic [SLOT_BITS-1:0] left_q;
  logic                 at_s1, at_s2, at_s3, at_s4;

  assign cur      = cmd_t'(slot_word);
  assign idx_hi   = cur.idx[IDX_W-1:1];
  assign in_range = {1'b0, idx_hi} < NREG_L;
  assign rd_addr  = idx_hi[RA_W-1:0];
  assign at_s1    = slot_vld && slot_num == 4'd1;
  assign at_s2    = slot_vld && slot_num == 4'd2;
  assign at_s3    = slot_vld && slot_num == 4'd3;
  assign at_s4    = slot_vld && slot_num == 4'd4;
  assign cmd_ok   = tagv.frame && tagv.s1 && (cur.rsvd == '0);

  // slot 2 completes the write staged at slot 1
  assign wr_en   = at_s2 && tagv.frame && tagv.s2 && wr_pend;
  assign wr_data = slot_word[SLOT_BITS-1 -: REG_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_pend       <= 1'b0;
      wr_addr       <= '0;
      rsp_valid     <= 1'b0;
      rsp_index     <= '0;
      rsp_data      <= '0;
      proto_err     <= 1'b0;
      mono_mismatch <= 1'b0;
      left_q        <= '0;
    end else begin
      if (at_s1) begin
        proto_err <= tagv.frame && tagv.s1 && (cur.rsvd != '0);
        wr_pend   <= cmd_ok && !cur.rd && !cur.idx[0] && in_range && (idx_hi != '0);
        wr_addr   <= rd_addr;
      end
      if (at_s1 && cmd_ok && cur.rd) begin
        rsp_valid <= 1'b1;
        rsp_index <= cur.idx;
        rsp_data  <= (cur.idx[0] || !in_range) ? '0 : rd_data;
      end else if (rsp_valid && rsp_ready) begin
        rsp_valid <= 1'b0;
      end
      if (at_s3) left_q <= slot_word;
      if (at_s4) mono_mismatch <= tagv.frame && tagv.s3 && tagv.s4 && (left_q != slot_word);
    end
  end
endmodule

// File: rtl/ac_cmd_port.sv
module ac_cmd_port
  import ac_cmd_pkg::*;
#(
  parameter int               NREG      = 64,
  parameter logic [REG_W-1:0] CAP_VALUE = 16'h6A90
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bit_en,
  input  logic                  sync,
  input  logic                  sdata,
  output logic                  rsp_valid,
  input  logic                  rsp_ready,
  output logic [IDX_W-1:0]      rsp_index,
  output logic [REG_W-1:0]      rsp_data,
  output logic [NREG*REG_W-1:0] reg_q,
  output logic                  proto_err,
  output logic                  mono_mismatch
);
  localparam int RA_W = $clog2(NREG);

  logic                 slot_vld;
  logic [3:0]           slot_num;
  logic [SLOT_BITS-1:0] slot_word;
  tagv_t                tagv;
  logic [RA_W-1:0]      rd_addr, wr_addr;
  logic [REG_W-1:0]     rd_data, wr_data;
  logic                 wr_en;

  ac_frame_deser u_deser (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .sync(sync), .sdata(sdata),
    .slot_vld(slot_vld), .slot_num(slot_num), .slot_word(slot_word), .tagv(tagv)
  );

  ac_cmd_exec #(.NREG(NREG)) u_exec (
    .clk(clk), .rst_n(rst_n), .slot_vld(slot_vld), .slot_num(slot_num),
    .slot_word(slot_word), .tagv(tagv), .rd_data(rd_data), .rd_addr(rd_addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_index(rsp_index),
    .rsp_data(rsp_data), .proto_err(proto_err), .mono_mismatch(mono_mismatch)
  );

  ac_reg_bank #(.NREG(NREG), .CAP_VALUE(CAP_VALUE)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .regs_flat(reg_q)
  );
endmodule

// File: rtl/ac_cmd_port_chk.sv
module ac_cmd_port_chk
  import ac_cmd_pkg::*;
#(
  parameter int NREG = 64
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  slot_vld,
  input logic [3:0]            slot_num,
  input logic                  rsp_valid,
  input logic                  rsp_ready,
  input logic [IDX_W-1:0]      rsp_index,
  input logic [REG_W-1:0]      rsp_data,
  input logic [NREG*REG_W-1:0] reg_q,
  input logic                  proto_err,
  input logic                  mono_mismatch
);
  p_slot_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    slot_vld |-> (slot_num >= 4'd1 && slot_num <= 4'(NUM_SLOTS)));

  p_write_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(slot_vld && slot_num == 4'd2) |=> $stable(reg_q));

  p_odd_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_index[0]) |-> rsp_data == '0);

  p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid);

  p_rsp_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready && !(slot_vld && slot_num == 4'd1))
      |=> ($stable(rsp_data) && $stable(rsp_index)));

  p_err_update_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(slot_vld && slot_num == 4'd1) |=> $stable(proto_err));

  p_mono_update_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(slot_vld && slot_num == 4'd4) |=> $stable(mono_mismatch));
endmodule

bind ac_cmd_port ac_cmd_port_chk #(.NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .slot_vld(slot_vld), .slot_num(slot_num),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_index(rsp_index),
  .rsp_data(rsp_data), .reg_q(reg_q), .proto_err(proto_err),
  .mono_mismatch(mono_mismatch)
);

// File: tb/ac_cmd_port_tb.sv
module ac_cmd_port_tb;
  localparam int          NREG = 64;
  localparam logic [15:0] CAP  = 16'h6A90;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_en = 1'b1;
  logic sync = 1'b0;
  logic sdata = 1'b0;
  logic rsp_ready = 1'b0;
  logic rsp_valid, proto_err, mono_mismatch;
  logic [6:0] rsp_index;
  logic [15:0] rsp_data;
  logic [NREG*16-1:0] reg_q;
  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  ac_cmd_port #(.NREG(NREG), .CAP_VALUE(CAP)) u_dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .sync(sync), .sdata(sdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_index(rsp_index),
    .rsp_data(rsp_data), .reg_q(reg_q), .proto_err(proto_err),
    .mono_mismatch(mono_mismatch)
  );

  // {is_read, index, data, slot2_valid, expected}
  localparam int VN = 12;
  localparam logic [40:0] VEC [VN] = '{
    {1'b0, 7'h02, 16'h1234, 1'b1, 16'h1234},
    {1'b0, 7'h04, 16'hABCD, 1'b1, 16'hABCD},
    {1'b0, 7'h7E, 16'hFFFF, 1'b1, 16'hFFFF},
    {1'b1, 7'h02, 16'h0000, 1'b0, 16'h1234},
    {1'b0, 7'h03, 16'h5555, 1'b1, 16'h1234},
    {1'b1, 7'h03, 16'h0000, 1'b0, 16'h0000},
    {1'b0, 7'h02, 16'h9999, 1'b0, 16'h1234},
    {1'b1, 7'h00, 16'h0000, 1'b0, CAP},
    {1'b0, 7'h00, 16'h1111, 1'b1, CAP},
    {1'b1, 7'h7E, 16'h0000, 1'b0, 16'hFFFF},
    {1'b0, 7'h02, 16'h0000, 1'b1, 16'h0000},
    {1'b1, 7'h04, 16'h0000, 1'b0, 16'hABCD}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send_frame(input logic [15:0] tag, input logic [19:0] s1,
                            input logic [19:0] s2, input logic [19:0] s3,
                            input logic [19:0] s4);
    logic [255:0] f;
    f = '0;
    f[255 -: 16] = tag;
    f[239 -: 20] = s1;
    f[219 -: 20] = s2;
    f[199 -: 20] = s3;
    f[179 -: 20] = s4;
    for (int i = 255; i >= 0; i--) begin
      @(negedge clk);
      sync  = (i >= 240);
      sdata = f[i];
    end
    @(negedge clk);
    sync = 1'b0;
    sdata = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [19:0] cmdw(input logic rd, input logic [6:0] idx,
                                       input logic [11:0] rsvd);
    return {rd, idx, rsvd};
  endfunction

  task automatic consume();
    @(negedge clk);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  function automatic logic [15:0] reg_at(input int n);
    return reg_q[n*16 +: 16];
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 cap reg", {16'h0, reg_at(0)}, {16'h0, CAP});
    chk("R1 other regs zero", {31'h0, reg_q[NREG*16-1:16] == '0}, 32'd1);
    chk("R1 rsp_valid", {31'h0, rsp_valid}, 32'd0);
    chk("R1 flags", {30'h0, proto_err, mono_mismatch}, 32'd0);

    // table walk: R2 R3 R4 R5 R6 R7 R8 R9
    for (int v = 0; v < VN; v++) begin
      logic        rd, s2v;
      logic [6:0]  idx;
      logic [15:0] dat, exp;
      {rd, idx, dat, s2v, exp} = VEC[v];
      send_frame(s2v ? 16'hE000 : 16'hC000, cmdw(rd, idx, 12'h0),
                 {dat, 4'hA}, 20'h0, 20'h0);
      if (rd) begin
        chk("R8 rsp_valid", {31'h0, rsp_valid}, 32'd1);
        chk("R8 rsp_index", {25'h0, rsp_index}, {25'h0, idx});
        chk("R8 R6 R7 rsp_data", {16'h0, rsp_data}, {16'h0, exp});
        consume();
        chk("R9 handshake clears valid", {31'h0, rsp_valid}, 32'd0);
      end else begin
        chk("R4 R5 R6 R7 reg value", {16'h0, reg_at(int'(idx[6:1]))}, {16'h0, exp});
      end
    end

    // R5 frame-valid bit clear
    send_frame(16'h6000, cmdw(1'b0, 7'h08, 12'h0), {16'h7777, 4'h3}, 20'h0, 20'h0);
    chk("R5 frame invalid write", {16'h0, reg_at(4)}, 32'h0);

    // R10 reserved bits
    send_frame(16'hE000, cmdw(1'b0, 7'h06, 12'h001), {16'hBEEF, 4'h0}, 20'h0, 20'h0);
    chk("R10 proto_err set", {31'h0, proto_err}, 32'd1);
    chk("R10 write dropped", {16'h0, reg_at(3)}, 32'h0);
    send_frame(16'hC000, cmdw(1'b1, 7'h04, 12'h800), 20'h0, 20'h0, 20'h0);
    chk("R10 read dropped", {31'h0, rsp_valid}, 32'd0);
    send_frame(16'hE000, cmdw(1'b0, 7'h06, 12'h000), {16'hBEEF, 4'h5}, 20'h0, 20'h0);
    chk("R10 proto_err clear", {31'h0, proto_err}, 32'd0);
    chk("R4 clean write", {16'h0, reg_at(3)}, 32'h0000BEEF);

    // R11 mono check
    send_frame(16'hF800, 20'h0, 20'h0, 20'h12345, 20'h12345);
    chk("R11 equal", {31'h0, mono_mismatch}, 32'd0);
    send_frame(16'hF800, 20'h0, 20'h0, 20'h12345, 20'h12344);
    chk("R11 differ", {31'h0, mono_mismatch}, 32'd1);
    send_frame(16'hF000, 20'h0, 20'h0, 20'h12345, 20'h54321);
    chk("R11 slot4 unmarked", {31'h0, mono_mismatch}, 32'd0);

    // R9 back-pressure and overwrite
    send_frame(16'hC000, cmdw(1'b1, 7'h04, 12'h0), 20'h0, 20'h0, 20'h0);
    send_frame(16'h0000, 20'h0, 20'h0, 20'h0, 20'h0);
    chk("R9 held valid", {31'h0, rsp_valid}, 32'd1);
    chk("R9 held data", {16'h0, rsp_data}, 32'h0000ABCD);
    send_frame(16'hC000, cmdw(1'b1, 7'h7E, 12'h0), 20'h0, 20'h0, 20'h0);
    chk("R9 overwrite index", {25'h0, rsp_index}, 32'h7E);
    chk("R9 overwrite data", {16'h0, rsp_data}, 32'h0000FFFF);
    consume();
    chk("R9 consumed", {31'h0, rsp_valid}, 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule